// File: doc/BRIEF.md
# Symmetric Decimating FIR Stage

This block is the decimating FIR stage of a PCM audio path, placed after a CIC decimator. It takes signed PCM samples qualified by a valid strobe and keeps a 55-sample history. Because the impulse response is symmetric, only 28 distinct coefficients are held: 27 that each weigh a pair of mirrored samples, and one centre tap. Each mirrored pair of samples is added before the multiply. The accumulated result is divided by a selectable power of two, rounded to nearest and saturated to the output width. A result is produced on every accepted sample, or on every second one.

The coefficients are 14-bit signed values. They are loaded through a simple write port that carries two coefficients per 32-bit word. They reset to a built-in low-pass response with droop correction, and they can be changed only while the stage is disabled. When the coefficient-enable input is low, the coefficients are bypassed. The newest sample is then passed through, and decimation and scaling still apply. This makes the stage useful for debugging with test patterns.

Top module: `fir_sym_decim`

## Requirements
- R1: While rst_ni is low, and until the first output event after reset, out_valid_o is 0 and out_o is 0.
- R2: After reset, coefficient c[i] for i = 0..27 takes the values -2, 21, 26, -17, -41, 25, 68, -33, -107, 41, 160, -48, -230, 54, 325, -56, -453, 51, 631, -31, -894, -21, 1326, 172, -2191, -770, 4859, 8191. Here c[27] is the centre tap.
- R3: A write with coef_we_i high and coef_addr_i = a, for a in 0..13, loads c[2a] from coef_wdata_i[13:0] and c[2a+1] from coef_wdata_i[29:16], both as two's complement. A write to address 14 or 15 changes nothing.
- R4: A coefficient write is ignored when enable_i is high at the same clock edge. This includes the edge at which enable_i rises.
- R5: With coef_en_i high, the unscaled result is sum over t = 0..54 of h[t]·x[t]. Here x[0] is the newest accepted sample, x[t] is the sample accepted t inputs earlier, h[t] = c[t] for t ≤ 27, and h[t] = c[54-t] for t > 27.
- R6: For scale_i = s, the result is (v + 2^(s-1)) >>> s when s > 0, and v when s = 0. The shift is arithmetic, so ties round upward.
- R7: A scaled value above 2^23-1 is output as 2^23-1, and a value below -2^23 is output as -2^23.
- R8: With dec_sel_i = 0, every accepted sample produces an output. With dec_sel_i = 1, every second accepted sample produces an output, the first one on the second sample accepted after enabling.
- R9: With coef_en_i low, v is the newest accepted sample, sign-extended. Decimation (R8) and scaling (R6, R7) still apply.
- R10: While enable_i is low, samples are ignored, the sample history is cleared to zero, the decimation phase is reset, and no output is produced. A sample presented at the edge where enable_i is low is dropped.
- R11: out_valid_o is high for exactly the one cycle after the clock edge that accepted the sample completing a decimation period. out_o holds its value until the next output event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Stage enable; low clears the history and allows coefficient writes |
| coef_en_i | input | 1 | 1: use the coefficients; 0: pass the newest sample through |
| dec_sel_i | input | 1 | Decimation code: 0 for ratio 1, 1 for ratio 2 |
| scale_i | input | 5 | Output right-shift amount, 0..31 |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 4 | Coefficient word address |
| coef_wdata_i | input | 32 | Coefficient word: two 14-bit coefficients |
| valid_i | input | 1 | Input sample valid |
| sample_i | input | 24 | Signed input sample |
| out_valid_o | output | 1 | Output sample valid, one-cycle pulse |
| out_o | output | 24 | Signed, scaled, rounded and saturated output |

## Verification
Two events can coincide with a change of enable_i at one clock edge. A coefficient write can arrive at the same edge where enable_i rises, and a valid sample can arrive at the same edge where enable_i falls. The bench drives each pair from the same falling edge. It then judges the outcome through the output. An impulse response shows that the written coefficient kept its old value. An output reflecting only the first sample after re-enabling shows that the dropped sample left no trace in the history. Decimation and scaling are also exercised together: with ratio 2, the bench checks both which inputs produce outputs and the rounded values of those outputs.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;
  localparam int COEF_W = 14;
  localparam int NTAPS  = 55;
  localparam int NUNIQ  = (NTAPS + 1) / 2;
  localparam int NREGS  = NUNIQ / 2;
  localparam int SH_W   = 5;

  function automatic logic signed [COEF_W-1:0] dflt_coef(input int idx);
    int v;
    case (idx)
      0: v = -2;     1: v = 21;    2: v = 26;     3: v = -17;
      4: v = -41;    5: v = 25;    6: v = 68;     7: v = -33;
      8: v = -107;   9: v = 41;    10: v = 160;   11: v = -48;
      12: v = -230;  13: v = 54;   14: v = 325;   15: v = -56;
      16: v = -453;  17: v = 51;   18: v = 631;   19: v = -31;
      20: v = -894;  21: v = -21;  22: v = 1326;  23: v = 172;
      24: v = -2191; 25: v = -770; 26: v = 4859;  27: v = 8191;
      default: v = 0;
    endcase
    return v[COEF_W-1:0];
  endfunction
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank
  import fir_sym_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enable_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [NUNIQ*COEF_W-1:0]   coef_o
);
  logic [2*COEF_W-1:0] word_q [NREGS];
  logic                wr_ok;
  logic                unused_bits;

  assign unused_bits = ^{wdata_i[31:30], wdata_i[15:14]};
  assign wr_ok = we_i && !enable_i && (int'(addr_i) < NREGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREGS; r++)
        word_q[r] <= {dflt_coef(2*r+1), dflt_coef(2*r)};
    end else if (wr_ok) begin
      word_q[addr_i] <= {wdata_i[16 +: COEF_W], wdata_i[0 +: COEF_W]};
    end
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_flat
    assign coef_o[2*r*COEF_W +: 2*COEF_W] = word_q[r];
  end

  AST_COEF_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> $stable(coef_o)); // R4
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(addr_i) >= NREGS) |=> $stable(coef_o)); // R3
endmodule

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
  parameter int IN_W  = 24,
  parameter int DEPTH = 54
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   push_i,
  input  logic [IN_W-1:0]        din_i,
  output logic [DEPTH*IN_W-1:0]  line_o
);
  logic [DEPTH*IN_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      line_q <= '0;
    else if (clr_i)   line_q <= '0;
    else if (push_i)  line_q <= {line_q[(DEPTH-1)*IN_W-1:0], din_i};
  end

  assign line_o = line_q;

  AST_LINE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (line_o == '0)); // R10
endmodule

// File: rtl/fir_sym_mac.sv
module fir_sym_mac
  import fir_sym_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int ACC_W = 45
) (
  input  logic signed [IN_W-1:0]          new_i,
  input  logic [(NTAPS-1)*IN_W-1:0]       line_i,
  input  logic [NUNIQ*COEF_W-1:0]         coef_i,
  output logic signed [ACC_W-1:0]         acc_o
);
  localparam int PRE_W  = IN_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;
  localparam int MID    = NUNIQ - 1;

  logic signed [IN_W-1:0]   win  [NTAPS];
  logic signed [PROD_W-1:0] prod [NUNIQ];

  always_comb begin
    win[0] = new_i;
    for (int t = 1; t < NTAPS; t++)
      win[t] = $signed(line_i[(t-1)*IN_W +: IN_W]);
  end

  for (genvar j = 0; j < MID; j++) begin : g_pair
    logic signed [PRE_W-1:0]  pre;
    logic signed [COEF_W-1:0] cf;
    assign cf      = $signed(coef_i[j*COEF_W +: COEF_W]);
    assign pre     = PRE_W'(win[j]) + PRE_W'(win[NTAPS-1-j]);
    assign prod[j] = PROD_W'(pre) * PROD_W'(cf);
  end

  logic signed [COEF_W-1:0] cf_mid;
  assign cf_mid    = $signed(coef_i[MID*COEF_W +: COEF_W]);
  assign prod[MID] = PROD_W'(win[MID]) * PROD_W'(cf_mid);

  always_comb begin
    acc_o = '0;
    for (int j = 0; j < NUNIQ; j++)
      acc_o = acc_o + ACC_W'(prod[j]);
  end
endmodule

// File: rtl/fir_out_stage.sv
module fir_out_stage
  import fir_sym_pkg::*;
#(
  parameter int ACC_W = 45,
  parameter int OUT_W = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fire_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic [SH_W-1:0]          scale_i,
  output logic                     vld_o,
  output logic signed [OUT_W-1:0]  data_o
);
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] rnd, sum, shf;
  logic signed [OUT_W-1:0] sat;

  always_comb begin
    rnd = '0;
    if (scale_i != '0) rnd = ACC_W'(1) << (scale_i - SH_W'(1));
    sum = acc_i + rnd;
    shf = sum >>> scale_i;
    if (shf > MAXV)      sat = MAXV[OUT_W-1:0];
    else if (shf < MINV) sat = MINV[OUT_W-1:0];
    else                 sat = shf[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= fire_i;
      if (fire_i) data_o <= sat;
    end
  end

  AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(data_o)); // R11
endmodule

// File: rtl/fir_sym_decim.sv
module fir_sym_decim
  import fir_sym_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int OUT_W  = 24,
  parameter int ADDR_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     enable_i,
  input  logic                     coef_en_i,
  input  logic                     dec_sel_i,
  input  logic [SH_W-1:0]          scale_i,
  input  logic                     coef_we_i,
  input  logic [ADDR_W-1:0]        coef_addr_i,
  input  logic [31:0]              coef_wdata_i,
  input  logic                     valid_i,
  input  logic signed [IN_W-1:0]   sample_i,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  out_o
);
  localparam int ACC_W = IN_W + 1 + COEF_W + $clog2(NUNIQ) + 1;

  logic [NUNIQ*COEF_W-1:0]    coef;
  logic [(NTAPS-1)*IN_W-1:0]  line;
  logic signed [ACC_W-1:0]    mac_acc, acc_sel;
  logic                       push, fire, phase_q;

  assign push = valid_i && enable_i;
  assign fire = push && (!dec_sel_i || phase_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= 1'b0;
    else if (!enable_i) phase_q <= 1'b0;
    else if (valid_i)   phase_q <= dec_sel_i ? !phase_q : 1'b0;
  end

  fir_coef_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk_i, .rst_ni, .enable_i,
    .we_i(coef_we_i), .addr_i(coef_addr_i), .wdata_i(coef_wdata_i),
    .coef_o(coef)
  );

  fir_tap_line #(.IN_W(IN_W), .DEPTH(NTAPS-1)) u_line (
    .clk_i, .rst_ni, .clr_i(!enable_i), .push_i(push),
    .din_i(sample_i), .line_o(line)
  );

  fir_sym_mac #(.IN_W(IN_W), .ACC_W(ACC_W)) u_mac (
    .new_i(sample_i), .line_i(line), .coef_i(coef), .acc_o(mac_acc)
  );

  assign acc_sel = coef_en_i ? mac_acc : ACC_W'(sample_i);

  fir_out_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
    .clk_i, .rst_ni, .fire_i(fire), .acc_i(acc_sel), .scale_i,
    .vld_o(out_valid_o), .data_o(out_o)
  );

  AST_OUT_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(valid_i && enable_i)); // R10
  AST_DEC2_NO_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dec_sel_i) |=> !(fire && dec_sel_i)); // R8
  if (IN_W <= OUT_W) begin : g_byp_chk
    AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && $past(!coef_en_i && scale_i == '0)) |-> (out_o == OUT_W'($past(sample_i)))); // R9
  end
endmodule

// File: tb/fir_sym_decim_tb.sv
`timescale 1ns/1ps
module fir_sym_decim_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, cen = 1, dec = 0, we = 0, vld = 0;
  logic [4:0] sc = 0;
  logic [3:0] addr = 0;
  logic [31:0] wd = 0;
  logic signed [23:0] smp = 0;
  logic ov;
  logic signed [23:0] out;

  int checks = 0, fails = 0;
  bit done = 0;
  longint c[28];
  longint hist[55];
  bit ph = 0;
  longint last_exp = 0;

  always #4 clk = ~clk;

  fir_sym_decim u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .coef_en_i(cen), .dec_sel_i(dec),
    .scale_i(sc), .coef_we_i(we), .coef_addr_i(addr), .coef_wdata_i(wd),
    .valid_i(vld), .sample_i(smp), .out_valid_o(ov), .out_o(out)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic longint model_out();
    longint acc = 0;
    if (cen) for (int t = 0; t < 55; t++) acc += c[(t <= 27) ? t : 54 - t] * hist[t];
    else acc = hist[0];
    if (sc != 0) acc += (64'sd1 <<< (sc - 1));
    acc = acc >>> sc;
    if (acc > 8388607) acc = 8388607;
    if (acc < -8388608) acc = -8388608;
    return acc;
  endfunction

  task automatic clear_model();
    for (int t = 0; t < 55; t++) hist[t] = 0;
    ph = 0;
  endtask

  task automatic push(input longint x, input string rq);
    bit fire = 0;
    @(negedge clk); smp = x[23:0]; vld = 1;
    @(negedge clk); vld = 0;
    if (en) begin
      for (int t = 54; t > 0; t--) hist[t] = hist[t-1];
      hist[0] = longint'(smp);
      fire = !dec || ph;
      ph = dec ? !ph : 1'b0;
    end
    chk(ov === fire, rq, longint'(ov), longint'(fire));
    if (fire) begin
      last_exp = model_out();
      chk(longint'(out) == last_exp, rq, longint'(out), last_exp);
    end
  endtask

  task automatic set_en(input bit b);
    @(negedge clk); en = b;
    if (!b) clear_model();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input longint d0, input longint d1);
    @(negedge clk); we = 1; addr = a[3:0];
    wd = {2'b00, d1[13:0], 2'b00, d0[13:0]};
    @(negedge clk); we = 0;
    if (!en && a < 14) begin c[2*a] = d0; c[2*a+1] = d1; end
  endtask

  task automatic impulse(input longint amp, input int n, input string rq);
    push(amp, rq);
    for (int i = 1; i < n; i++) push(0, rq);
  endtask

  task automatic t_reset();
    chk(ov === 1'b0, "R1 valid in reset", longint'(ov), 0);
    chk(out === 24'sd0, "R1 data in reset", longint'(out), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(ov === 1'b0 && out === 24'sd0, "R1 after reset", longint'(out), 0);
  endtask

  task automatic t_default_coefs();
    cen = 1; dec = 0; sc = 0;
    set_en(1);
    impulse(1, 55, "R2 default impulse");
    push(0, "R11 tail");
    @(negedge clk);
    chk(ov === 1'b0, "R11 single pulse", longint'(ov), 0);
    chk(longint'(out) == last_exp, "R11 hold", longint'(out), last_exp);
  endtask

  task automatic t_mix_scale();
    int unsigned s = 32'h1234;
    sc = 8;
    for (int i = 0; i < 70; i++) begin
      s = s * 1103515245 + 12345;
      push(longint'($signed(s[23:4])), "R5 R6 mixed data");
    end
    sc = 13;
    for (int i = 0; i < 60; i++) push(1000, "R6 dc scale13");
    chk(longint'(out) == ((13921 * 1000 + 4096) >>> 13), "R6 dc gain", longint'(out), (13921 * 1000 + 4096) >>> 13);
  endtask

  task automatic t_sat();
    sc = 0;
    for (int i = 0; i < 30; i++) push(8388607, "R7 positive");
    chk(out === 24'sd8388607, "R7 pos clamp", longint'(out), 8388607);
    for (int i = 0; i < 60; i++) push(-8388608, "R7 negative");
    chk(out === -24'sd8388608, "R7 neg clamp", longint'(out), -8388608);
  endtask

  task automatic t_disable_drop();
    @(negedge clk); smp = 24'sd777; vld = 1; en = 0;
    @(negedge clk); vld = 0; clear_model();
    chk(ov === 1'b0, "R10 sample at disable edge", longint'(ov), 0);
    push(9, "R10 while disabled");
    set_en(1);
    push(5, "R10 history cleared");
    chk(longint'(out) == 5 * c[0], "R10 first after enable", longint'(out), 5 * c[0]);
  endtask

  task automatic t_writes();
    set_en(0);
    wr(3, 100, -200);
    wr(13, 4000, -8192);
    wr(14, 1111, 2222);
    wr(15, 3333, 4444);
    @(negedge clk); we = 1; addr = 0; wd = {2'b00, 14'd500, 2'b00, 14'd600}; en = 1;
    @(negedge clk); we = 0;
    impulse(2, 55, "R3 R4 written coefs");
    chk(c[6] == 100 && c[7] == -200 && c[0] == -2, "R3 model sanity", c[6], 100);
  endtask

  task automatic t_dec2();
    int nout = 0;
    set_en(0);
    dec = 1; sc = 2;
    set_en(1);
    for (int i = 0; i < 8; i++) begin
      push(longint'(i * 3000 - 7000), "R8 ratio two");
      if (ov) nout++;
    end
    chk(nout == 4, "R8 output count", nout, 4);
  endtask

  task automatic t_bypass();
    set_en(0);
    dec = 0; cen = 0; sc = 0;
    set_en(1);
    push(-12345, "R9 pass");
    chk(out === -24'sd12345, "R9 pass value", longint'(out), -12345);
    sc = 1;
    push(3, "R9 R6 round up");
    chk(out === 24'sd2, "R6 3>>1", longint'(out), 2);
    push(-3, "R9 R6 round neg");
    chk(out === -24'sd1, "R6 -3>>1", longint'(out), -1);
    sc = 31;
    push(-8388608, "R6 max shift");
    dec = 1; sc = 0;
    set_en(0); set_en(1);
    push(10, "R9 R8 bypass dec");
    push(20, "R9 R8 bypass dec");
    chk(out === 24'sd20, "R9 R8 decimated value", longint'(out), 20);
  endtask

  initial begin
    for (int i = 0; i < 28; i++) c[i] = 0;
    c[0]=-2; c[1]=21; c[2]=26; c[3]=-17; c[4]=-41; c[5]=25; c[6]=68; c[7]=-33;
    c[8]=-107; c[9]=41; c[10]=160; c[11]=-48; c[12]=-230; c[13]=54; c[14]=325;
    c[15]=-56; c[16]=-453; c[17]=51; c[18]=631; c[19]=-31; c[20]=-894; c[21]=-21;
    c[22]=1326; c[23]=172; c[24]=-2191; c[25]=-770; c[26]=4859; c[27]=8191;
    clear_model();
    repeat (3) @(negedge clk);
    t_reset();
    t_default_coefs();
    t_mix_scale();
    t_sat();
    t_disable_drop();
    t_writes();
    t_dec2();
    t_bypass();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule